// File: doc/BRIEF.md
# Piecewise-Quadratic Sine Amplitude Generator

This block turns a 15-bit phase word into a 14-bit signed sine sample. It serves as the phase-to-amplitude stage after a phase accumulator. It keeps no sine lookup memory. The three most significant phase bits pick one of eight octants. Odd octants mirror the offset by complementing it. Octants whose sine follows a cosine shape switch to a second set of coefficients. The lower half of the cycle negates the result.

The folded offset splits into a 3-bit segment number and a 9-bit position inside that segment. Each of the sixteen segment entries (eight sine-shaped, eight cosine-shaped) holds three fixed-point constants. The constants are derived from the word widths when the design is elaborated. The linear term is one radix-4 Booth product. A narrow square of the truncated offset supplies the curvature term. The Booth partial products, the constant term and the curvature term are reduced in carry-save form. One carry-propagate adder then resolves the sum. After that come rounding, clamping and the sign.

The pipeline has four register stages and accepts a new phase on every clock.

Top module: `sinpoly_conv`

## Requirements
- R1: For every phase p from 0 to 32767, amp_o equals round(8191 * sin(2*pi*(p + 0.5)/32768)) to within 2 LSB. The output is two's complement.
- R2: Each phase sampled on a rising edge appears on amp_o after the fourth rising edge, counting the sampling edge as the first. Until then, amp_o keeps the result of the earlier phase. One result comes out per clock.
- R3: While rst_n is low, amp_o reads 0.
- R4: A phase with bit 14 clear gives amp_o >= 0, and a phase with bit 14 set gives amp_o <= 0. Phases p and p + 16384 give exact negatives of each other.
- R5: For p below 16384, phases p and 16383 - p give identical amp_o. This is the exact mirror about a quarter cycle.
- R6: amp_o never reads -8192. Phases 8191 and 8192 give a value between 8189 and 8191.
- R7: Phases at the first and last offset of each 512-step segment meet the tolerance of R1. There is no jump where the segment or the coefficient set changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_i | input | 15 | Phase word; full scale is one cycle |
| amp_o | output | 14 | Signed sine amplitude, registered |

## Verification
On every cycle, the bound checker enforces several properties:
- the zero output during reset;
- the absence of the most negative code;
- the sign that follows the top phase bit four cycles earlier;
- a steady output whenever the phase has been steady;
- the near-full-scale value at the positive peak.

Some properties need many cycles of stimulus and are shown only by the bench:
- the numerical accuracy against a real sine over the whole phase circle;
- the exact antisymmetry and mirror pairings;
- the behaviour at segment boundaries;
- the cycle on which a phase change reaches the output.

// File: rtl/sinpoly_pkg.sv
package sinpoly_pkg;

  // pi scaled by 2^30
  localparam longint PI_Q30 = 64'sd3373259426;
  localparam int     QF     = 30;

  typedef enum int {K_C0, K_C1, K_C2} coef_kind_e;

  function automatic longint rnd_shr(longint v, int n);
    return (v + (longint'(1) <<< (n - 1))) >>> n;
  endfunction

  // sine of a Q30 angle below one radian, odd power series
  function automatic longint sin_q30(longint x);
    longint acc;
    longint trm;
    acc = 0;
    trm = x;
    for (int k = 1; k <= 7; k++) begin
      acc = acc + trm;
      trm = -((((trm * x) >>> QF) * x) >>> QF) / longint'((2 * k) * (2 * k + 1));
    end
    return acc;
  endfunction

  // cosine of a Q30 angle below one radian, even power series
  function automatic longint cos_q30(longint x);
    longint acc;
    longint trm;
    acc = 0;
    trm = longint'(1) <<< QF;
    for (int k = 1; k <= 7; k++) begin
      acc = acc + trm;
      trm = -((((trm * x) >>> QF) * x) >>> QF) / longint'((2 * k - 1) * (2 * k));
    end
    return acc;
  endfunction

  // Segment constants, expanded about the segment centre.
  // Entries below 2^seg_bits follow sine, the others follow cosine.
  // c0 carries the half-LSB rounding offset of the final scaling.
  function automatic longint coef_val(coef_kind_e kind, int k, int seg_bits,
                                      int off_w, int frac, int sq_sh, longint amp);
    int     nseg;
    bit     cset;
    int     s;
    int     e1;
    int     e2;
    longint th;
    longint sv;
    longint cv;
    longint base;
    longint t;
    nseg = 1 << seg_bits;
    cset = (k >= nseg);
    s    = cset ? k - nseg : k;
    e1   = frac - off_w - 3;
    e2   = frac + 2 * sq_sh - 2 * off_w - 7;
    th   = longint'(2 * s + 1) * PI_Q30 / (longint'(8) <<< seg_bits);
    sv   = sin_q30(th);
    cv   = cos_q30(th);
    case (kind)
      K_C0: begin
        base = cset ? cv : sv;
        return rnd_shr(amp * base, QF - frac) + (longint'(1) <<< (frac - 1));
      end
      K_C1: begin
        base = cset ? -sv : cv;
        t    = (amp * base) >>> 15;
        return rnd_shr(t * PI_Q30, 45 - e1);
      end
      default: begin
        base = cset ? -cv : -sv;
        t    = (amp * base) >>> 15;
        t    = (t * PI_Q30) >>> QF;
        t    = t * PI_Q30;
        return rnd_shr(t, 45 - e2);
      end
    endcase
  endfunction

endpackage

// File: rtl/sinpoly_fold.sv
module sinpoly_fold #(
  parameter int PHASE_W  = 15,
  parameter int SEG_BITS = 3
) (
  input  logic [PHASE_W-1:0]         phase_i,
  output logic [SEG_BITS:0]          idx_o,
  output logic signed [PHASE_W-SEG_BITS-3:0] e_o,
  output logic                       neg_o
);
  localparam int OFF_W = PHASE_W - 3;
  localparam int X_W   = OFF_W - SEG_BITS;

  logic [2:0]       oct;
  logic [OFF_W-1:0] off;
  logic [OFF_W-1:0] off_f;
  logic [X_W-1:0]   xpos;

  always_comb begin
    oct   = phase_i[PHASE_W-1 -: 3];
    off   = phase_i[OFF_W-1:0];
    off_f = oct[0] ? ~off : off;
    xpos  = off_f[X_W-1:0];
    // sine-shaped octants 0,3 use set 0; cosine-shaped 1,2 use set 1
    idx_o = {oct[0] ^ oct[1], off_f[OFF_W-1 -: SEG_BITS]};
    // odd centred offset 2x+1-2^X_W
    e_o   = {~xpos[X_W-1], xpos[X_W-2:0], 1'b1};
    neg_o = oct[2];
  end
endmodule

// File: rtl/sinpoly_coef.sv
module sinpoly_coef
  import sinpoly_pkg::*;
#(
  parameter int SEG_BITS = 3,
  parameter int OFF_W    = 12,
  parameter int FRAC     = 16,
  parameter int SQ_SH    = 3,
  parameter int AMP_W    = 14,
  parameter int ACC_W    = 32,
  parameter int C1_W     = 18,
  parameter int C2_W     = 10
) (
  input  logic [SEG_BITS:0]        idx_i,
  output logic signed [ACC_W-1:0]  c0_o,
  output logic signed [C1_W-1:0]   c1_o,
  output logic signed [C2_W-1:0]   c2_o
);
  localparam int     NTAB = 2 ** (SEG_BITS + 1);
  localparam longint AMP  = (longint'(1) <<< (AMP_W - 1)) - 1;

  logic signed [ACC_W-1:0] c0_t [NTAB];
  logic signed [C1_W-1:0]  c1_t [NTAB];
  logic signed [C2_W-1:0]  c2_t [NTAB];

  for (genvar k = 0; k < NTAB; k++) begin : g_tab
    localparam longint V0 = coef_val(K_C0, k, SEG_BITS, OFF_W, FRAC, SQ_SH, AMP);
    localparam longint V1 = coef_val(K_C1, k, SEG_BITS, OFF_W, FRAC, SQ_SH, AMP);
    localparam longint V2 = coef_val(K_C2, k, SEG_BITS, OFF_W, FRAC, SQ_SH, AMP);
    assign c0_t[k] = ACC_W'(V0);
    assign c1_t[k] = C1_W'(V1);
    assign c2_t[k] = C2_W'(V2);
  end

  assign c0_o = c0_t[idx_i];
  assign c1_o = c1_t[idx_i];
  assign c2_o = c2_t[idx_i];
endmodule

// File: rtl/sinpoly_booth.sv
module sinpoly_booth #(
  parameter int C1_W  = 18,
  parameter int E_W   = 10,
  parameter int ACC_W = 32,
  localparam int N_DIG = (E_W + 1) / 2
) (
  input  logic signed [C1_W-1:0]   m_i,
  input  logic signed [E_W-1:0]    e_i,
  output logic [N_DIG*ACC_W-1:0]   pp_o
);
  localparam int EP_W = 2 * N_DIG;

  logic [EP_W:0]           ep;
  logic signed [ACC_W-1:0] m1;
  logic signed [ACC_W-1:0] m2;

  assign ep = {EP_W'(e_i), 1'b0};
  assign m1 = ACC_W'(m_i);
  assign m2 = m1 <<< 1;

  for (genvar i = 0; i < N_DIG; i++) begin : g_dig
    logic [2:0]              grp;
    logic signed [ACC_W-1:0] pv;
    assign grp = ep[2*i +: 3];
    always_comb begin
      case (grp)
        3'b001, 3'b010: pv = m1;
        3'b011:         pv = m2;
        3'b100:         pv = -m2;
        3'b101, 3'b110: pv = -m1;
        default:        pv = '0;
      endcase
    end
    assign pp_o[i*ACC_W +: ACC_W] = pv <<< (2 * i);
  end
endmodule

// File: rtl/sinpoly_csa.sv
module sinpoly_csa #(
  parameter int N_OPS = 7,
  parameter int W     = 32
) (
  input  logic [N_OPS*W-1:0] ops_i,
  output logic [W-1:0]       sum_o,
  output logic [W-1:0]       carry_o
);
  logic [W-1:0] s_w [N_OPS-1];
  logic [W-1:0] c_w [N_OPS-1];

  assign s_w[0] = ops_i[0 +: W];
  assign c_w[0] = ops_i[W +: W];

  for (genvar j = 0; j < N_OPS - 2; j++) begin : g_fa
    logic [W-1:0] d;
    assign d          = ops_i[(j+2)*W +: W];
    assign s_w[j+1]   = s_w[j] ^ c_w[j] ^ d;
    assign c_w[j+1]   = ((s_w[j] & c_w[j]) | (s_w[j] & d) | (c_w[j] & d)) << 1;
  end

  assign sum_o   = s_w[N_OPS-2];
  assign carry_o = c_w[N_OPS-2];
endmodule

// File: rtl/sinpoly_conv.sv
module sinpoly_conv #(
  parameter int PHASE_W  = 15,
  parameter int AMP_W    = 14,
  parameter int SEG_BITS = 3,
  parameter int FRAC     = 16,
  parameter int SQ_SH    = 3,
  parameter int ACC_W    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PHASE_W-1:0]       phase_i,
  output logic signed [AMP_W-1:0]  amp_o
);
  localparam int OFF_W = PHASE_W - 3;
  localparam int X_W   = OFF_W - SEG_BITS;
  localparam int E_W   = X_W + 1;
  localparam int ER_W  = E_W + 1;
  localparam int N_DIG = (E_W + 1) / 2;
  localparam int N_OPS = N_DIG + 2;
  localparam int C1_W  = 18;
  localparam int C2_W  = 10;
  localparam logic signed [ACC_W-1:0] AMP_MAX_X = ACC_W'((1 << (AMP_W - 1)) - 1);
  localparam logic signed [AMP_W-1:0] AMP_MAX   = AMP_W'((1 << (AMP_W - 1)) - 1);

  // stage 1: folded phase
  logic [SEG_BITS:0]        idx_d,  idx_q;
  logic signed [E_W-1:0]    e_d,    e_q;
  logic                     neg1_d, neg1_q;
  // stage 2: partial products and constant terms
  logic [N_DIG*ACC_W-1:0]   pp_d,   pp_q;
  logic signed [ACC_W-1:0]  c0_d,   c0_q;
  logic signed [ACC_W-1:0]  c2t_d,  c2t_q;
  logic                     neg2_q;
  // stage 3: redundant sum
  logic [ACC_W-1:0]         sum_d,  sum_q;
  logic [ACC_W-1:0]         car_d,  car_q;
  logic                     neg3_q;
  // stage 4: output
  logic signed [AMP_W-1:0]  amp_d,  amp_q;

  logic signed [C1_W-1:0]   c1_w;
  logic signed [C2_W-1:0]   c2_w;
  logic signed [ER_W-1:0]   e_r;
  logic signed [ER_W-1:0]   eh;
  logic signed [ACC_W-1:0]  eh_x;
  logic signed [ACC_W-1:0]  c2_x;
  logic signed [ACC_W-1:0]  y;
  logic signed [ACC_W-1:0]  y_sh;
  logic signed [AMP_W-1:0]  mag;

  sinpoly_fold #(.PHASE_W(PHASE_W), .SEG_BITS(SEG_BITS)) u_fold (
    .phase_i (phase_i),
    .idx_o   (idx_d),
    .e_o     (e_d),
    .neg_o   (neg1_d)
  );

  sinpoly_coef #(
    .SEG_BITS(SEG_BITS), .OFF_W(OFF_W), .FRAC(FRAC), .SQ_SH(SQ_SH),
    .AMP_W(AMP_W), .ACC_W(ACC_W), .C1_W(C1_W), .C2_W(C2_W)
  ) u_coef (
    .idx_i (idx_q),
    .c0_o  (c0_d),
    .c1_o  (c1_w),
    .c2_o  (c2_w)
  );

  sinpoly_booth #(.C1_W(C1_W), .E_W(E_W), .ACC_W(ACC_W)) u_booth (
    .m_i  (c1_w),
    .e_i  (e_q),
    .pp_o (pp_d)
  );

  sinpoly_csa #(.N_OPS(N_OPS), .W(ACC_W)) u_csa (
    .ops_i   ({c2t_q, c0_q, pp_q}),
    .sum_o   (sum_d),
    .carry_o (car_d)
  );

  // curvature term from the rounded, truncated offset
  always_comb begin
    e_r   = {e_q[E_W-1], e_q} + ER_W'(1 << (SQ_SH - 1));
    eh    = e_r >>> SQ_SH;
    eh_x  = ACC_W'(eh);
    c2_x  = ACC_W'(c2_w);
    c2t_d = c2_x * (eh_x * eh_x);
  end

  // single carry-propagate add, scale, clamp, sign
  always_comb begin
    y    = signed'(sum_q + car_q);
    y_sh = y >>> FRAC;
    if (y_sh < 0)              mag = '0;
    else if (y_sh > AMP_MAX_X) mag = AMP_MAX;
    else                       mag = y_sh[AMP_W-1:0];
    amp_d = neg3_q ? -mag : mag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      e_q    <= '0;
      neg1_q <= 1'b0;
      pp_q   <= '0;
      c0_q   <= '0;
      c2t_q  <= '0;
      neg2_q <= 1'b0;
      sum_q  <= '0;
      car_q  <= '0;
      neg3_q <= 1'b0;
      amp_q  <= '0;
    end else begin
      idx_q  <= idx_d;
      e_q    <= e_d;
      neg1_q <= neg1_d;
      pp_q   <= pp_d;
      c0_q   <= c0_d;
      c2t_q  <= c2t_d;
      neg2_q <= neg1_q;
      sum_q  <= sum_d;
      car_q  <= car_d;
      neg3_q <= neg2_q;
      amp_q  <= amp_d;
    end
  end

  assign amp_o = amp_q;
endmodule

// File: rtl/sinpoly_conv_chk.sv
module sinpoly_conv_chk #(
  parameter int PHASE_W = 15,
  parameter int AMP_W   = 14
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [PHASE_W-1:0]      phase_i,
  input logic signed [AMP_W-1:0] amp_o
);
  localparam logic signed [AMP_W-1:0] A_MAX  = AMP_W'((1 << (AMP_W - 1)) - 1);
  localparam logic signed [AMP_W-1:0] A_MIN  = -A_MAX - AMP_W'(1);
  localparam logic [PHASE_W-1:0]      P_PEAK = PHASE_W'(1 << (PHASE_W - 2));

  // edges since reset release, saturating at 5
  logic [2:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            warm_q <= '0;
    else if (warm_q != 3'd5) warm_q <= warm_q + 3'd1;
  end

  a_r3_reset_zero: assert property (@(posedge clk) !rst_n |-> amp_o == '0);

  a_r6_no_min_code: assert property (@(posedge clk) disable iff (!rst_n)
    amp_o != A_MIN);

  a_r4_sign_pos: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q >= 3'd4 && !$past(phase_i[PHASE_W-1], 4)) |-> !amp_o[AMP_W-1]);

  a_r4_sign_neg: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q >= 3'd4 && $past(phase_i[PHASE_W-1], 4)) |-> (amp_o[AMP_W-1] || amp_o == '0));

  a_r6_peak: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q >= 3'd4 && $past(phase_i, 4) == P_PEAK) |-> amp_o >= A_MAX - AMP_W'(2));

  a_r2_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 3'd5 && $past(phase_i, 4) == $past(phase_i, 5)) |-> amp_o == $past(amp_o));
endmodule

bind sinpoly_conv sinpoly_conv_chk #(.PHASE_W(PHASE_W), .AMP_W(AMP_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .phase_i (phase_i),
  .amp_o   (amp_o)
);

// File: tb/sim_sinpoly_conv.sv
`timescale 1ns/1ps
module sim_sinpoly_conv;
  localparam int PW  = 15;
  localparam int AW  = 14;
  localparam int LAT = 4;
  localparam int NPH = 1 << PW;

  logic                 clk;
  logic                 rst_n;
  logic [PW-1:0]        phase;
  logic signed [AW-1:0] amp;

  int n_chk;
  int n_err;
  bit done;

  sinpoly_conv u0 (.clk(clk), .rst_n(rst_n), .phase_i(phase), .amp_o(amp));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int ref_amp(int p);
    real r;
    r = 8191.0 * $sin(2.0 * 3.14159265358979 * (real'(p) + 0.5) / real'(NPH));
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
  endfunction

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic check(input bit ok, input string req, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic measure(input int p, output int a);
    @(negedge clk);
    phase = PW'(p);
    repeat (LAT) @(negedge clk);
    a = amp;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog got=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    int a0, a1, a2, p, lbl;
    n_chk = 0;
    n_err = 0;
    done  = 1'b0;
    void'($urandom(32'h5eed_0017));
    rst_n = 1'b0;
    phase = PW'(24576);
    repeat (3) @(negedge clk);
    check(amp == 0, "R3 reset", amp, 0);
    rst_n = 1'b1;

    // R2: fill with negative peak, then step to positive peak
    repeat (6) @(negedge clk);
    check(amp <= -8189, "R2 settled", amp, -8191);
    phase = PW'(8192);
    for (int k = 1; k <= LAT; k++) begin
      @(negedge clk);
      if (k < LAT) check(amp <= -8189, "R2 held", amp, -8191);
      else         check(amp >= 8189,  "R2 arrival", amp, 8191);
    end

    // R1/R7/R6: full sweep, one phase per cycle
    for (int k = 0; k < NPH + LAT; k++) begin
      @(negedge clk);
      if (k >= LAT) begin
        p   = k - LAT;
        lbl = p % 512;
        if (lbl == 0 || lbl == 511)
          check(iabs(amp - ref_amp(p)) <= 2, "R7 segment edge", amp, ref_amp(p));
        else
          check(iabs(amp - ref_amp(p)) <= 2, "R1 sweep", amp, ref_amp(p));
        check(amp != -8192, "R6 min code", amp, -8191);
      end
      if (k < NPH) phase = PW'(k);
    end

    // R6 directed peaks
    measure(8191, a0);
    check(a0 >= 8189 && a0 <= 8191, "R6 peak 8191", a0, 8191);
    measure(8192, a0);
    check(a0 >= 8189 && a0 <= 8191, "R6 peak 8192", a0, 8191);
    measure(24575, a0);
    check(a0 <= -8189 && a0 >= -8191, "R6 trough", a0, -8191);

    // R4 directed at zero crossings
    measure(0, a0);
    check(a0 >= 0, "R4 zero pos", a0, ref_amp(0));
    measure(16384, a1);
    check(a1 <= 0 && a1 == -a0, "R4 zero neg", a1, -a0);

    // R4/R5/R1: random pairings
    for (int n = 0; n < 600; n++) begin
      p = int'($urandom % 16384);
      measure(p, a0);
      measure(p + 16384, a1);
      measure(16383 - p, a2);
      check(iabs(a0 - ref_amp(p)) <= 2, "R1 random", a0, ref_amp(p));
      check(a0 >= 0, "R4 upper half sign", a0, ref_amp(p));
      check(a1 == -a0, "R4 antisymmetry", a1, -a0);
      check(a2 == a0, "R5 mirror", a2, a0);
    end

    // R3: reset asserted mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(amp == 0, "R3 reset mid-run", amp, 0);
    @(negedge clk);
    check(amp == 0, "R3 reset held", amp, 0);
    rst_n = 1'b1;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule